// File: doc/BRIEF.md
# Thread-Aware Operand Forwarding and Stall Unit

This block sits beside the decode stage of an in-order pipeline that may issue instructions from the same hardware thread on consecutive cycles. Every thread owns a private register bank. Each cycle the block compares the two source register numbers and the thread tag of the instruction in decode against the destinations held in the execute, memory and write-back stages. From that comparison it decides, for each operand, whether the value comes from the register file or from one of the three forwarding paths. When the value is not yet ready, it asks for a stall.

Only results produced by the ALU may be forwarded out of execute or memory. A multiply or a load whose destination is needed while it is still in execute or memory makes the block raise a stall. The decode instruction is then held, and the block kills the write-enable of the copy that enters execute on the next cycle. That copy becomes a bubble. Anything that has reached write-back can be forwarded whatever produced it. This closes the window in which write-back writes the register file on the same edge that decode would read it.

Top module: `fwd_stall_unit`

## Requirements
- R1: A source operand whose register equals the execute-stage destination, with the same thread tag, an active effective execute write-enable, and producer kind ALU (code 0), gets select code 1 (execute path).
- R2: If execute does not match, an operand that matches the memory stage gets select code 2, provided that stage holds an ALU (kind 0) result.
- R3: If neither execute nor memory matches, an operand that matches the write-back stage gets select code 3, whatever its producer kind.
- R4: If the youngest matching stage is execute or memory and its kind is not ALU, that operand requests a stall. Non-ALU kinds are multiply 1, load 2 and 3 reserved. The operand's select code is then 0.
- R5: When several stages match, the youngest decides the outcome, with execute taking priority over memory and memory over write-back.
- R6: A stage whose thread tag differs from the decode thread tag never matches.
- R7: A stage whose write-enable is low never matches. A destination of register 0 never matches. With no match, the select code is 0 (register file).
- R8: After any cycle in which stall_o is high, ex_we_o is 0 for one cycle, and the execute stage cannot match in that cycle. In every other cycle, ex_we_o equals ex_we_i.
- R9: During reset, ex_we_o follows ex_we_i.
- R10: The two operands are resolved independently. stall_o is the OR of the two operand stall requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dec_tid_i | input | TID_W | Thread tag of decode instruction |
| dec_ra_i | input | REG_AW | First source register in decode |
| dec_rb_i | input | REG_AW | Second source register in decode |
| ex_rd_i | input | REG_AW | Execute-stage destination |
| ex_tid_i | input | TID_W | Execute-stage thread tag |
| ex_we_i | input | 1 | Execute-stage write-enable as latched |
| ex_kind_i | input | 2 | Execute producer kind (0 ALU, 1 multiply, 2 load, 3 reserved) |
| mem_rd_i | input | REG_AW | Memory-stage destination |
| mem_tid_i | input | TID_W | Memory-stage thread tag |
| mem_we_i | input | 1 | Memory-stage write-enable |
| mem_kind_i | input | 2 | Memory producer kind |
| wb_rd_i | input | REG_AW | Write-back destination |
| wb_tid_i | input | TID_W | Write-back thread tag |
| wb_we_i | input | 1 | Write-back write-enable |
| fwd_a_o | output | 2 | First operand select (0 file, 1 execute, 2 memory, 3 write-back) |
| fwd_b_o | output | 2 | Second operand select |
| stall_o | output | 1 | Hold decode and inject a bubble |
| ex_we_o | output | 1 | Effective execute write-enable (bubble-masked) |

## Verification
Some checks hold on every cycle: each nonzero select code points at a stage that really holds a matching, enabled producer of the same thread; register 0 never selects a forwarding path; every stall traces back to a non-ALU producer in execute or memory; and a stall is always followed by a killed execute write-enable. The priority order among several matching stages cannot be shown by a per-cycle implication. Neither can the fact that a stage is ignored when its tag or enable disagrees, nor the exact code chosen in each combination. Those come from the bench, which sweeps thousands of pseudo-random stage contents over a four-register, two-thread space and compares every output with a model built from the requirements.

// File: rtl/fwd_hz_pkg.sv
package fwd_hz_pkg;

   localparam int unsigned N_STG = 3;
   localparam int unsigned N_SRC = 2;
   localparam int unsigned KIND_W = 2;

   localparam logic [KIND_W-1:0] KIND_ALU = 2'd0;

   typedef enum logic [1:0] {
      SEL_RF  = 2'd0,
      SEL_EX  = 2'd1,
      SEL_MEM = 2'd2,
      SEL_WB  = 2'd3
   } fwd_sel_e;

endpackage

// File: rtl/hz_stage_cmp.sv
module hz_stage_cmp #(
   parameter int unsigned REG_AW = 5,
   parameter int unsigned TID_W  = 1
) (
   input  logic [REG_AW-1:0] src_i,
   input  logic [TID_W-1:0]  src_tid_i,
   input  logic [REG_AW-1:0] dst_i,
   input  logic [TID_W-1:0]  dst_tid_i,
   input  logic              dst_we_i,
   output logic              hit_o
);
   localparam logic [REG_AW-1:0] ZERO_REG = '0;

   always_comb begin
      hit_o = dst_we_i
            && (dst_i != ZERO_REG)
            && (dst_i == src_i)
            && (dst_tid_i == src_tid_i);
   end
endmodule

// File: rtl/hz_src_resolve.sv
module hz_src_resolve
   import fwd_hz_pkg::*;
#(
   parameter int unsigned REG_AW = 5,
   parameter int unsigned TID_W  = 1
) (
   input  logic [REG_AW-1:0] src_i,
   input  logic [TID_W-1:0]  tid_i,
   input  logic [REG_AW-1:0] stg_rd_i  [N_STG],
   input  logic [TID_W-1:0]  stg_tid_i [N_STG],
   input  logic              stg_we_i  [N_STG],
   input  logic              stg_alu_i [N_STG],
   output fwd_sel_e          sel_o,
   output logic              stall_o
);
   localparam int unsigned LAST = N_STG - 1;

   logic hit [N_STG];

   for (genvar s = 0; s < N_STG; s++) begin : g_cmp
      hz_stage_cmp #(.REG_AW(REG_AW), .TID_W(TID_W)) cmp_i (
         .src_i    (src_i),
         .src_tid_i(tid_i),
         .dst_i    (stg_rd_i[s]),
         .dst_tid_i(stg_tid_i[s]),
         .dst_we_i (stg_we_i[s]),
         .hit_o    (hit[s])
      );
   end

   // Walk from the oldest stage to the youngest so the youngest hit is left standing.
   always_comb begin
      sel_o   = SEL_RF;
      stall_o = 1'b0;
      for (int s = LAST; s >= 0; s--) begin
         if (hit[s]) begin
            if (stg_alu_i[s] || (s == LAST)) begin
               sel_o   = fwd_sel_e'(2'(s + 1));
               stall_o = 1'b0;
            end else begin
               sel_o   = SEL_RF;
               stall_o = 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/hz_bubble_reg.sv
module hz_bubble_reg (
   input  logic clk,
   input  logic rst_n,
   input  logic stall_i,
   output logic bubble_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bubble_o <= 1'b0;
      else        bubble_o <= stall_i;
   end
endmodule

// File: rtl/fwd_stall_unit.sv
module fwd_stall_unit
   import fwd_hz_pkg::*;
#(
   parameter int unsigned REG_AW = 5,
   parameter int unsigned TID_W  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TID_W-1:0]  dec_tid_i,
   input  logic [REG_AW-1:0] dec_ra_i,
   input  logic [REG_AW-1:0] dec_rb_i,
   input  logic [REG_AW-1:0] ex_rd_i,
   input  logic [TID_W-1:0]  ex_tid_i,
   input  logic              ex_we_i,
   input  logic [1:0]        ex_kind_i,
   input  logic [REG_AW-1:0] mem_rd_i,
   input  logic [TID_W-1:0]  mem_tid_i,
   input  logic              mem_we_i,
   input  logic [1:0]        mem_kind_i,
   input  logic [REG_AW-1:0] wb_rd_i,
   input  logic [TID_W-1:0]  wb_tid_i,
   input  logic              wb_we_i,
   output logic [1:0]        fwd_a_o,
   output logic [1:0]        fwd_b_o,
   output logic              stall_o,
   output logic              ex_we_o
);
   if (REG_AW < 1) begin : g_bad_aw
      $error("REG_AW must be at least 1");
   end
   if (TID_W < 1) begin : g_bad_tw
      $error("TID_W must be at least 1");
   end
   if (N_STG != 3) begin : g_bad_stg
      $error("select encoding assumes three producer stages");
   end

   logic              bubble_q;
   logic [REG_AW-1:0] stg_rd  [N_STG];
   logic [TID_W-1:0]  stg_tid [N_STG];
   logic              stg_we  [N_STG];
   logic              stg_alu [N_STG];
   logic [REG_AW-1:0] src     [N_SRC];
   fwd_sel_e          sel     [N_SRC];
   logic              src_stall [N_SRC];

   assign ex_we_o = ex_we_i & ~bubble_q;

   assign stg_rd[0]  = ex_rd_i;
   assign stg_tid[0] = ex_tid_i;
   assign stg_we[0]  = ex_we_o;
   assign stg_alu[0] = (ex_kind_i == KIND_ALU);
   assign stg_rd[1]  = mem_rd_i;
   assign stg_tid[1] = mem_tid_i;
   assign stg_we[1]  = mem_we_i;
   assign stg_alu[1] = (mem_kind_i == KIND_ALU);
   assign stg_rd[2]  = wb_rd_i;
   assign stg_tid[2] = wb_tid_i;
   assign stg_we[2]  = wb_we_i;
   assign stg_alu[2] = 1'b1;

   assign src[0] = dec_ra_i;
   assign src[1] = dec_rb_i;

   for (genvar k = 0; k < N_SRC; k++) begin : g_src
      hz_src_resolve #(.REG_AW(REG_AW), .TID_W(TID_W)) res_i (
         .src_i    (src[k]),
         .tid_i    (dec_tid_i),
         .stg_rd_i (stg_rd),
         .stg_tid_i(stg_tid),
         .stg_we_i (stg_we),
         .stg_alu_i(stg_alu),
         .sel_o    (sel[k]),
         .stall_o  (src_stall[k])
      );
   end

   always_comb begin
      stall_o = 1'b0;
      for (int k = 0; k < N_SRC; k++) stall_o = stall_o | src_stall[k];
   end

   assign fwd_a_o = sel[0];
   assign fwd_b_o = sel[1];

   hz_bubble_reg bub_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .stall_i (stall_o),
      .bubble_o(bubble_q)
   );
endmodule

// File: rtl/fwd_stall_chk.sv
module fwd_stall_chk #(
   parameter int unsigned REG_AW = 5,
   parameter int unsigned TID_W  = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [TID_W-1:0]  dec_tid_i,
   input logic [REG_AW-1:0] dec_ra_i,
   input logic [REG_AW-1:0] dec_rb_i,
   input logic [REG_AW-1:0] ex_rd_i,
   input logic [TID_W-1:0]  ex_tid_i,
   input logic              ex_we_i,
   input logic [1:0]        ex_kind_i,
   input logic [REG_AW-1:0] mem_rd_i,
   input logic [TID_W-1:0]  mem_tid_i,
   input logic              mem_we_i,
   input logic [1:0]        mem_kind_i,
   input logic [REG_AW-1:0] wb_rd_i,
   input logic [TID_W-1:0]  wb_tid_i,
   input logic              wb_we_i,
   input logic [1:0]        fwd_a_o,
   input logic [1:0]        fwd_b_o,
   input logic              stall_o,
   input logic              ex_we_o
);
   // R8
   bubble_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stall_o |=> !ex_we_o);

   // R8
   we_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(stall_o) |-> (ex_we_o == ex_we_i));

   // R1
   ex_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fwd_a_o == 2'd1) |-> (ex_we_o && ex_rd_i == dec_ra_i
                             && ex_tid_i == dec_tid_i && ex_kind_i == 2'd0));

   // R2
   mem_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fwd_b_o == 2'd2) |-> (mem_we_i && mem_rd_i == dec_rb_i
                             && mem_tid_i == dec_tid_i && mem_kind_i == 2'd0));

   // R6
   wb_tid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fwd_b_o == 2'd3) |-> (wb_we_i && wb_tid_i == dec_tid_i && wb_rd_i == dec_rb_i));

   // R7
   zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((fwd_a_o != 2'd0) |-> (dec_ra_i != '0)) and ((fwd_b_o != 2'd0) |-> (dec_rb_i != '0)));

   // R4
   stall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stall_o |-> ((ex_we_o && ex_kind_i != 2'd0) || (mem_we_i && mem_kind_i != 2'd0)));
endmodule

bind fwd_stall_unit fwd_stall_chk #(.REG_AW(REG_AW), .TID_W(TID_W)) chk_i (.*);

// File: tb/fwd_stall_unit_tb_top.sv
module fwd_stall_unit_tb_top;
   localparam int AW = 2;
   localparam int TW = 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [TW-1:0] dec_tid;
   logic [AW-1:0] dec_ra, dec_rb, ex_rd, mem_rd, wb_rd;
   logic [TW-1:0] ex_tid, mem_tid, wb_tid;
   logic ex_we, mem_we, wb_we;
   logic [1:0] ex_kind, mem_kind;
   logic [1:0] fwd_a, fwd_b;
   logic stall, ex_we_out;

   int n_chk = 0;
   int n_fail = 0;
   logic [31:0] rng = 32'h1234_5678;

   always #2 clk = ~clk;

   fwd_stall_unit #(.REG_AW(AW), .TID_W(TW)) dut_i (
      .clk(clk), .rst_n(rst_n), .dec_tid_i(dec_tid), .dec_ra_i(dec_ra), .dec_rb_i(dec_rb),
      .ex_rd_i(ex_rd), .ex_tid_i(ex_tid), .ex_we_i(ex_we), .ex_kind_i(ex_kind),
      .mem_rd_i(mem_rd), .mem_tid_i(mem_tid), .mem_we_i(mem_we), .mem_kind_i(mem_kind),
      .wb_rd_i(wb_rd), .wb_tid_i(wb_tid), .wb_we_i(wb_we),
      .fwd_a_o(fwd_a), .fwd_b_o(fwd_b), .stall_o(stall), .ex_we_o(ex_we_out));

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Model: returns {stall, code[1:0]} and the number of matching stages.
   function automatic logic [2:0] model(input logic [AW-1:0] s, input logic bub, output int nhit);
      logic ex_m, mem_m, wb_m;
      ex_m  = ex_we && !bub && ex_rd == s && s != 0 && ex_tid == dec_tid;
      mem_m = mem_we && mem_rd == s && s != 0 && mem_tid == dec_tid;
      wb_m  = wb_we && wb_rd == s && s != 0 && wb_tid == dec_tid;
      nhit = int'(ex_m) + int'(mem_m) + int'(wb_m);
      if (ex_m)  return (ex_kind == 0) ? 3'b001 : 3'b100;
      if (mem_m) return (mem_kind == 0) ? 3'b010 : 3'b100;
      if (wb_m)  return 3'b011;
      return 3'b000;
   endfunction

   function automatic string tag_of(input logic [2:0] r, input int nhit);
      if (nhit > 1) return "R5";
      case (r)
         3'b001: return "R1";
         3'b010: return "R2";
         3'b011: return "R3";
         3'b100: return "R4";
         default: return "R6 R7";
      endcase
   endfunction

   function automatic logic [31:0] nxt(input logic [31:0] x);
      logic [31:0] y;
      y = x ^ (x << 13);
      y = y ^ (y >> 17);
      return y ^ (y << 5);
   endfunction

   initial begin
      #400000;
      n_fail++;
      n_chk++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic bub;
      logic prev_stall;
      logic [2:0] ra_r, rb_r;
      int ha, hb;
      {dec_tid, dec_ra, dec_rb, ex_rd, mem_rd, wb_rd} = '0;
      {ex_tid, mem_tid, wb_tid, ex_we, mem_we, wb_we, ex_kind, mem_kind} = '0;
      // R9: write-enable passes through during reset
      repeat (2) @(negedge clk);
      ex_we = 1'b1;
      #1;
      check("R9 reset we", int'(ex_we_out), 1);
      check("R9 reset stall", int'(stall), 0);
      ex_we = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      prev_stall = 1'b0;
      for (int cyc = 0; cyc < 6000; cyc++) begin
         @(negedge clk);
         bub = prev_stall;
         rng = nxt(rng);
         dec_ra = rng[1:0]; dec_rb = rng[3:2]; dec_tid = rng[4];
         ex_rd = rng[6:5]; ex_tid = (rng[7] & rng[8]) ? ~rng[4] : rng[4];
         ex_we = rng[9]; ex_kind = rng[11:10];
         mem_rd = rng[13:12]; mem_tid = (rng[14] & rng[15]) ? ~rng[4] : rng[4];
         mem_we = rng[16]; mem_kind = (rng[17] | rng[18]) ? 2'd0 : rng[20:19];
         wb_rd = rng[22:21]; wb_tid = (rng[23] & rng[24]) ? ~rng[4] : rng[4];
         wb_we = rng[25] | rng[26];
         if (rng[31:29] == 3'd0) begin
            ex_rd = dec_ra; mem_rd = dec_ra; wb_rd = dec_ra;   // R5 pile-up
         end
         #1;
         ra_r = model(dec_ra, bub, ha);
         rb_r = model(dec_rb, bub, hb);
         check({tag_of(ra_r, ha), " opA"}, int'(fwd_a), int'(ra_r[1:0]));
         check({tag_of(rb_r, hb), " opB"}, int'(fwd_b), int'(rb_r[1:0]));
         // R10: stall is the OR of both operands
         check("R10 stall", int'(stall), int'(ra_r[2] | rb_r[2]));
         // R8: bubble kills the execute write-enable
         check("R8 ex_we", int'(ex_we_out), int'(ex_we & ~bub));
         prev_stall = ra_r[2] | rb_r[2];
      end
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule